// File: doc/BRIEF.md
# Cycle-Dependent System Address Driver

This block sits in a system peripheral bridge and controls the bridge's side of the system address bus. On every clock it takes an encoded bus-cycle type and decides which groups of address lines the bridge drives and which it leaves floating. It also decides what value goes on the driven lines. The value can come from the CPU's upper address bits, from a DMA address that is generated elsewhere, from bits of the DMA page register, or from an internal 8-bit refresh row counter.

The lines fall into five groups: bits 0..7 (low), bits 8..9 (mid), bits 10..16 (body), bits 17..19 (page) and bits 20..23 (top). Each group has a value output and an output enable. The enables are registered from the cycle type. A registered active-low write-back snoop strobe overrides them combinationally and floats the mid, page and top groups while a DMA cycle is running.

Top module: `sysaddr_drive`

## Requirements
- R1: `cyc_type` and `wback_n` are sampled on the rising clock edge, and every output reflects the value sampled at the most recent edge. While `rst_n` is low, all five enables are low and the refresh counter is 00h.
- R2: Cycle code 3'b000 (CPU or local master) enables only the page group, which carries `cpu_hi`.
- R3: Cycle code 3'b001 (DMA) enables all five groups. Each group carries the matching bits of `dma_addr`: low=[7:0], mid=[9:8], body=[16:10], page=[19:17], top=[23:20].
- R4: Cycle code 3'b010 (bus master on the expansion bus) enables no group.
- R5: Cycle code 3'b011 (hidden refresh) enables the low group, which carries the refresh counter, and the page group, which carries `dma_page[3:1]`. No other group is enabled.
- R6: Cycle code 3'b100 (master refresh) enables only the low group, which carries the refresh counter. The page group floats.
- R7: The refresh counter increments on each clock edge where `rfsh_done` is high, and it wraps from FFh to 00h. A refresh cycle in the same sampled state already shows the incremented value.
- R8: When `wback_n` was sampled low during a DMA cycle, the mid, page and top enables are low while the low and body groups stay enabled. All three return at the first edge that samples `wback_n` high.
- R9: A low `wback_n` has no effect on the enables or values in any cycle type other than DMA.
- R10: Cycle codes 3'b101 to 3'b111 enable no group.
- R11: Every value output is zero while its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_type | input | 3 | Encoded bus-cycle type |
| wback_n | input | 1 | Active-low write-back snoop strobe |
| cpu_hi | input | 3 | CPU address bits 17..19 |
| dma_addr | input | 24 | DMA address from the DMA engine |
| dma_page | input | 8 | DMA page register value |
| rfsh_done | input | 1 | One-cycle pulse at the end of each refresh |
| out_lo | output | 8 | Address bits 0..7 |
| oe_lo | output | 1 | Enable for bits 0..7 |
| out_mid | output | 2 | Address bits 8..9 |
| oe_mid | output | 1 | Enable for bits 8..9 |
| out_body | output | 7 | Address bits 10..16 |
| oe_body | output | 1 | Enable for bits 10..16 |
| out_page | output | 3 | Address bits 17..19 |
| oe_page | output | 1 | Enable for bits 17..19 |
| out_top | output | 4 | Address bits 20..23 |
| oe_top | output | 1 | Enable for bits 20..23 |

## Verification
Two events can land on the same edge. In the first, a snoop strobe is sampled low on the same edge that moves the cycle type into or out of DMA. In the second, a refresh-done pulse arrives on the edge that starts a refresh cycle. The sweep applies every cycle code with both strobe levels in turn, so a low strobe meets each DMA entry and exit directly. Counter pulses are issued together with refresh cycle codes. An arithmetic model in the bench predicts the enable pattern, which is the DMA pattern masked only when the strobe sampled on that same edge was low. It also predicts a low-group value that already includes that edge's increment.

// File: rtl/sysaddr_drive.sv
module sysaddr_drive (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cyc_type,
  input  logic        wback_n,
  input  logic [2:0]  cpu_hi,
  input  logic [23:0] dma_addr,
  input  logic [7:0]  dma_page,
  input  logic        rfsh_done,
  output logic [7:0]  out_lo,
  output logic        oe_lo,
  output logic [1:0]  out_mid,
  output logic        oe_mid,
  output logic [6:0]  out_body,
  output logic        oe_body,
  output logic [2:0]  out_page,
  output logic        oe_page,
  output logic [3:0]  out_top,
  output logic        oe_top
);
  localparam logic [2:0] CT_CPU  = 3'd0;
  localparam logic [2:0] CT_DMA  = 3'd1;
  localparam logic [2:0] CT_ISAM = 3'd2;
  localparam logic [2:0] CT_HREF = 3'd3;
  localparam logic [2:0] CT_MREF = 3'd4;
  localparam logic [2:0] CT_IDLE = 3'd7;

  logic [2:0] cyc_q;
  logic       snoop_q;
  logic [7:0] rcnt;
  logic       en_lo, en_mid, en_body, en_page, en_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= CT_IDLE;
      snoop_q <= 1'b1;
      rcnt    <= 8'h00;
      en_lo   <= 1'b0;
      en_mid  <= 1'b0;
      en_body <= 1'b0;
      en_page <= 1'b0;
      en_top  <= 1'b0;
    end else begin
      cyc_q   <= cyc_type;
      snoop_q <= wback_n;
      if (rfsh_done) rcnt <= rcnt + 8'd1;
      en_lo   <= (cyc_type == CT_DMA) || (cyc_type == CT_HREF) || (cyc_type == CT_MREF);
      en_mid  <= (cyc_type == CT_DMA);
      en_body <= (cyc_type == CT_DMA);
      en_page <= (cyc_type == CT_CPU) || (cyc_type == CT_DMA) || (cyc_type == CT_HREF);
      en_top  <= (cyc_type == CT_DMA);
    end
  end

  logic wb_float;
  logic is_rfsh;
  assign wb_float = !snoop_q && (cyc_q == CT_DMA);
  assign is_rfsh  = (cyc_q == CT_HREF) || (cyc_q == CT_MREF);

  assign oe_lo   = en_lo;
  assign oe_body = en_body;
  assign oe_mid  = en_mid  && !wb_float;
  assign oe_page = en_page && !wb_float;
  assign oe_top  = en_top  && !wb_float;

  logic [2:0] page_src;
  always_comb begin
    case (cyc_q)
      CT_CPU:  page_src = cpu_hi;
      CT_HREF: page_src = dma_page[3:1];
      default: page_src = dma_addr[19:17];
    endcase
  end

  assign out_lo   = oe_lo   ? (is_rfsh ? rcnt : dma_addr[7:0]) : 8'h00;
  assign out_mid  = oe_mid  ? dma_addr[9:8]   : 2'b00;
  assign out_body = oe_body ? dma_addr[16:10] : 7'h00;
  assign out_page = oe_page ? page_src        : 3'b000;
  assign out_top  = oe_top  ? dma_addr[23:20] : 4'h0;

  // R4
  isa_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cyc_type) == CT_ISAM) |->
      !(oe_lo || oe_mid || oe_body || oe_page || oe_top));

  // R6
  mref_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cyc_type) == CT_MREF) |-> (oe_lo && !oe_page));

  // R7
  rcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rfsh_done)) |-> (rcnt == $past(rcnt) + 8'd1));

  // R7
  rcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rfsh_done)) |-> $stable(rcnt));

  // R8
  wb_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wback_n) && $past(cyc_type) == CT_DMA) |->
      (!oe_mid && !oe_page && !oe_top && oe_lo && oe_body));

  // R3
  dma_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wback_n) && $past(cyc_type) == CT_DMA) |->
      (oe_lo && oe_mid && oe_body && oe_page && oe_top));

  // R11
  zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_top |-> out_top == 4'h0) and (!oe_mid |-> out_mid == 2'b00));
endmodule

// File: tb/sysaddr_drive_tb.sv
module sysaddr_drive_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cyc_type = 3'd7;
  logic        wback_n = 1'b1;
  logic [2:0]  cpu_hi = '0;
  logic [23:0] dma_addr = '0;
  logic [7:0]  dma_page = '0;
  logic        rfsh_done = 1'b0;
  logic [7:0]  out_lo;
  logic [1:0]  out_mid;
  logic [6:0]  out_body;
  logic [2:0]  out_page;
  logic [3:0]  out_top;
  logic        oe_lo, oe_mid, oe_body, oe_page, oe_top;

  int checks = 0;
  int errors = 0;
  int cnt_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysaddr_drive u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .wback_n(wback_n),
    .cpu_hi(cpu_hi), .dma_addr(dma_addr), .dma_page(dma_page), .rfsh_done(rfsh_done),
    .out_lo(out_lo), .oe_lo(oe_lo), .out_mid(out_mid), .oe_mid(oe_mid),
    .out_body(out_body), .oe_body(oe_body), .out_page(out_page), .oe_page(oe_page),
    .out_top(out_top), .oe_top(oe_top)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int ct, input bit wb);
    if (ct == 1 && !wb) return "R8";
    if (ct != 1 && !wb) return "R9";
    case (ct)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input int ct, input bit wb, input bit rd);
    @(negedge clk);
    cyc_type  = ct[2:0];
    wback_n   = wb;
    rfsh_done = rd;
    @(negedge clk);
    rfsh_done = 1'b0;
    if (rd) cnt_m = (cnt_m + 1) % 256;
  endtask

  task automatic expect_all(input int ct, input bit wb);
    bit e_lo, e_mid, e_body, e_page, e_top, fl;
    int v_lo, v_page;
    string r;
    r = req_of(ct, wb);
    e_lo   = (ct == 1 || ct == 3 || ct == 4);
    e_mid  = (ct == 1);
    e_body = (ct == 1);
    e_page = (ct == 0 || ct == 1 || ct == 3);
    e_top  = (ct == 1);
    fl = (ct == 1) && !wb;
    if (fl) begin e_mid = 0; e_page = 0; e_top = 0; end
    v_lo   = !e_lo ? 0 : ((ct == 3 || ct == 4) ? cnt_m : (dma_addr & 8'hFF));
    v_page = !e_page ? 0 : (ct == 0 ? cpu_hi : (ct == 3 ? ((dma_page >> 1) & 7) : ((dma_addr >> 17) & 7)));
    chk(r, "oe_lo",   oe_lo,   e_lo);
    chk(r, "oe_mid",  oe_mid,  e_mid);
    chk(r, "oe_body", oe_body, e_body);
    chk(r, "oe_page", oe_page, e_page);
    chk(r, "oe_top",  oe_top,  e_top);
    chk(r, "out_lo",   out_lo,   v_lo);
    chk(r, "out_page", out_page, v_page);
    chk("R11", "out_mid",  out_mid,  e_mid  ? ((dma_addr >> 8) & 3)     : 0);
    chk("R11", "out_body", out_body, e_body ? ((dma_addr >> 10) & 7'h7F) : 0);
    chk("R11", "out_top",  out_top,  e_top  ? ((dma_addr >> 20) & 4'hF)  : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset enables", {oe_lo, oe_mid, oe_body, oe_page, oe_top}, 0);
    rst_n = 1'b1;
    step(3, 1, 0);
    chk("R1", "reset counter", out_lo, 0);

    for (int pat = 0; pat < 4; pat++) begin
      dma_addr = 24'hA5C3E1 ^ (pat * 24'h35B1F7);
      dma_page = 8'h5A + 8'(pat * 37);
      cpu_hi   = 3'(pat * 3 + 1);
      for (int ct = 0; ct < 8; ct++) begin
        for (int w = 0; w < 2; w++) begin
          step(ct, w[0], (ct == 3 || ct == 4) && w == 1);
          expect_all(ct, w[0]);
        end
      end
    end

    // R8 resume: strobe low then high inside DMA
    step(1, 0, 0);
    expect_all(1, 0);
    step(1, 1, 0);
    chk("R8", "resume oe_page", oe_page, 1);
    expect_all(1, 1);

    // R7 counter wrap with coinciding refresh cycles
    for (int i = 0; i < 300; i++) begin
      step((i % 2) ? 3 : 4, 1, 1);
      chk("R7", "refresh count", out_lo, cnt_m);
    end
    step(4, 1, 0);
    chk("R7", "hold without pulse", out_lo, cnt_m);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule